// File: doc/BRIEF.md
# BCD Real-Time Clock Register Core

This block keeps calendar time in packed BCD: seconds, minutes, hours, day of month, month and two-digit year. A free-running divider counts enables from a 32.768 kHz timebase and produces one step per second. The step ripples through the calendar fields, and each month has a fixed length of 28, 30 or 31 days. A byte-wide register port with an auto-incrementing pointer gives access to the eight time bytes and to a bank of control bytes. The same port sets the oscillator-stop, halt-update and square-wave controls.

Host software reads a consistent view of the time. The first access to any time byte freezes the visible copy, while the internal counters keep running underneath. When the access ends, the visible copy is reloaded from the counters, so no seconds are lost. An access ends either with a stop strobe or with an access to a control byte. A halt-update control bit holds the visible copy in the same way for as long as software keeps it set. A programmable square-wave output is taken from the divider chain.

Top module: `rtc_bcd_core`

## Requirements
- R1: After synchronous reset, every time byte and every control byte reads 0x00, `rdata` is 0x00, and `rdata_vld` and `sqw_out` are low.
- R2: Seconds and minutes (field bits 6:0) count in BCD, wrap from 0x59 to 0x00 and carry into the next field.
- R3: Hours (field bits 5:0) wrap from 0x23 to 0x00 and carry into the date.
- R4: The date (field bits 5:0) wraps to 0x01 after day 0x28 of month 0x02, after day 0x30 of months 0x04, 0x06, 0x09 and 0x11, and after day 0x31 of every other month. The month (bits 4:0) wraps from 0x12 to 0x01, and the year (8 bits) wraps from 0x99 to 0x00.
- R5: While bit 7 of the seconds byte (offset 1) is 1, neither the calendar nor the divider advances. Writing that bit as 0 restarts counting.
- R6: Counting preserves the bits above each field: minutes bit 7, hours bits 7:6, date bits 7:6 and month bits 7:5.
- R7: A write to any time byte (offsets 0 to 7) loads it at once and clears the divider. The next second therefore comes exactly 2^DIV_W enables after the write.
- R8: A read or write of a time byte freezes the visible time bytes. A `bus_stop` strobe or an access to a control byte (offset 8 or above) releases them, and they are reloaded from the running counters.
- R9: While bit 6 of control byte 0x0C is 1, the visible time bytes stay frozen. Writes to time bytes still show in the visible copy.
- R10: `bus_start` loads the pointer from `bus_addr`. Every read or write then uses the pointer and increments it by one, so a burst of 8 reads from offset 0 returns all the time bytes.
- R11: `sqw_out` is driven only when bit 6 of byte 0x0A is 1. The rate code is bits 7:4 of byte 0x13. Code 0 holds the output low, and code 1 follows the 32.768 kHz enable one cycle late. A code c from 2 to 15 gives a period of 2^c enables.
- R12: Read data and `rdata_vld` appear on the clock edge after the edge that samples `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | Clock enable at the 32.768 kHz timebase rate |
| bus_start | input | 1 | Load the register pointer from `bus_addr` |
| bus_addr | input | $clog2(NREG) | Start offset of an access |
| bus_wr | input | 1 | Write `bus_wdata` at the pointer, then increment it |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read at the pointer, then increment it |
| bus_stop | input | 1 | End of access; releases a freeze |
| rdata | output | 8 | Registered read data |
| rdata_vld | output | 1 | High for one cycle when `rdata` carries a read result |
| sqw_out | output | 1 | Square-wave output |

## Verification
Read results are due one clock edge after the edge that samples `bus_rd`. The scoreboard pushes each expected byte before it raises the strobe and pops it at the falling edge after `rdata_vld` rises. Calendar effects are timed by counting enables, not cycles. A write clears the divider, so exactly 2^DIV_W enables later the seconds step. The bench reads after 2^DIV_W-1 enables, where no step is yet due, and again after one more enable. Square-wave periods are measured between rising edges of `sqw_out`. The output is registered, so it trails the divider by one cycle, and the period is unaffected.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int TIME_BYTES = 8;
  localparam int TIX_W      = $clog2(TIME_BYTES);
  // time byte positions
  localparam int SEC_O  = 1;
  localparam int MIN_O  = 2;
  localparam int HR_O   = 3;
  localparam int DATE_O = 5;
  localparam int MON_O  = 6;
  localparam int YR_O   = 7;
  // control byte positions and bits
  localparam int SQEN_O   = 'h0A;
  localparam int HALT_O   = 'h0C;
  localparam int RATE_O   = 'h13;
  localparam int CTL_BIT  = 6;
  localparam int RATE_W   = 4;

  typedef logic [TIME_BYTES-1:0][7:0] tbank_t;

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] month_end(input logic [4:0] m);
    case (m)
      5'h02:                      return 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescale.sv
`timescale 1ns/1ps
module rtc_prescale #(
  parameter int DIV_W  = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              clr,
  input  logic              sq_en,
  input  logic [RATE_W-1:0] sq_code,
  output logic              sec_stb,
  output logic              sq_out
);
  localparam int NTAP = 2**RATE_W;
  localparam logic [DIV_W-1:0] DIV_MAX = '1;

  logic [DIV_W-1:0] div;
  logic [NTAP-1:0]  tap;

  assign sec_stb = tick & run & ~clr & (div == DIV_MAX);

  always_ff @(posedge clk) begin
    if (rst)              div <= '0;
    else if (clr)         div <= '0;
    else if (tick && run) div <= div + DIV_W'(1);
  end

  assign tap[0] = 1'b0;
  assign tap[1] = tick;
  for (genvar c = 2; c < NTAP; c++) begin : g_tap
    if (c - 1 < DIV_W) begin : g_on
      assign tap[c] = div[c-1];
    end else begin : g_off
      assign tap[c] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sq_out <= 1'b0;
    else     sq_out <= sq_en & tap[sq_code];
  end

  // R11: disabled or code 0 keeps the output low
  a_r11_sq_quiet: assert property (@(posedge clk) disable iff (rst)
    (!sq_en || sq_code == '0) |=> !sq_out);
  // R7: right after a clear no second step is possible
  a_r7_no_early_step: assert property (@(posedge clk) disable iff (rst)
    clr |=> !sec_stb);
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_stb,
  input  logic             ld_en,
  input  logic [TIX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  output tbank_t           tm
);
  tbank_t nxt;

  always_comb begin
    nxt = tm;
    nxt[SEC_O][6:0] = 7'(bcd_step({1'b0, tm[SEC_O][6:0]}));
    if (tm[SEC_O][6:0] == 7'h59) begin
      nxt[SEC_O][6:0] = '0;
      nxt[MIN_O][6:0] = 7'(bcd_step({1'b0, tm[MIN_O][6:0]}));
      if (tm[MIN_O][6:0] == 7'h59) begin
        nxt[MIN_O][6:0] = '0;
        nxt[HR_O][5:0]  = 6'(bcd_step({2'b0, tm[HR_O][5:0]}));
        if (tm[HR_O][5:0] == 6'h23) begin
          nxt[HR_O][5:0]   = '0;
          nxt[DATE_O][5:0] = 6'(bcd_step({2'b0, tm[DATE_O][5:0]}));
          if (tm[DATE_O][5:0] == month_end(tm[MON_O][4:0])) begin
            nxt[DATE_O][5:0] = 6'h01;
            nxt[MON_O][4:0]  = 5'(bcd_step({3'b0, tm[MON_O][4:0]}));
            if (tm[MON_O][4:0] == 5'h12) begin
              nxt[MON_O][4:0] = 5'h01;
              nxt[YR_O]       = (tm[YR_O] == 8'h99) ? 8'h00 : bcd_step(tm[YR_O]);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          tm <= '0;
    else if (ld_en)   tm[ld_idx] <= ld_data;
    else if (sec_stb) tm <= nxt;
  end

  // R5: with the stop bit set and no write, nothing moves
  a_r5_stop_holds: assert property (@(posedge clk) disable iff (rst)
    (tm[SEC_O][7] && !ld_en) |=> $stable(tm));
  // R6: flag bits above the fields survive counting
  a_r6_flags_kept: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> (tm[MIN_O][7] == $past(tm[MIN_O][7]) &&
                tm[HR_O][7:6] == $past(tm[HR_O][7:6]) &&
                tm[DATE_O][7:6] == $past(tm[DATE_O][7:6]) &&
                tm[MON_O][7:5] == $past(tm[MON_O][7:5])));
endmodule

// File: rtl/rtc_regport.sv
`timescale 1ns/1ps
module rtc_regport
  import rtc_pkg::*;
#(
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_stop,
  input  tbank_t            tm,
  output logic [7:0]        rdata,
  output logic              rdata_vld,
  output logic              ld_en,
  output logic [TIX_W-1:0]  ld_idx,
  output logic [7:0]        ld_data,
  output logic              halt,
  output logic              sq_en,
  output logic [RATE_W-1:0] sq_code
);
  logic [AW-1:0] ptr;
  logic          freeze;
  tbank_t        snap;
  logic [7:0]    ctl [NREG];
  logic          acc_rd, acc_wr, is_time, hold;

  assign acc_rd  = bus_rd & ~bus_start;
  assign acc_wr  = bus_wr & ~bus_start;
  assign is_time = ptr < AW'(TIME_BYTES);
  assign hold    = freeze | halt;

  assign ld_en   = acc_wr & is_time;
  assign ld_idx  = ptr[TIX_W-1:0];
  assign ld_data = bus_wdata;

  assign halt    = ctl[HALT_O][CTL_BIT];
  assign sq_en   = ctl[SQEN_O][CTL_BIT];
  assign sq_code = ctl[RATE_O][7 -: RATE_W];

  always_ff @(posedge clk) begin
    if (rst)                  ptr <= '0;
    else if (bus_start)       ptr <= bus_addr;
    else if (acc_rd | acc_wr) ptr <= ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                  freeze <= 1'b0;
    else if (bus_stop)        freeze <= 1'b0;
    else if (acc_rd | acc_wr) freeze <= is_time;
  end

  always_ff @(posedge clk) begin
    if (rst) snap <= '0;
    else begin
      if (!hold) snap <= tm;
      if (ld_en) snap[ld_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) ctl[i] <= '0;
    end else if (acc_wr && !is_time) begin
      ctl[ptr] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata_vld <= acc_rd;
      if (acc_rd) rdata <= is_time ? snap[ptr[TIX_W-1:0]] : ctl[ptr];
    end
  end

  // R10: each access advances the pointer by one
  a_r10_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (acc_rd || acc_wr) |=> ptr == $past(ptr) + AW'(1));
  // R12: read results one edge later, and only then
  a_r12_rd_latency: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> rdata_vld);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> !rdata_vld);
  // R8: a frozen view only changes through writes
  a_r8_frozen_view: assert property (@(posedge clk) disable iff (rst)
    (freeze && !ld_en) |=> $stable(snap));
  // R9: halt-update holds the view
  a_r9_halt_view: assert property (@(posedge clk) disable iff (rst)
    (halt && !ld_en) |=> $stable(snap));
endmodule

// File: rtl/rtc_bcd_core.sv
`timescale 1ns/1ps
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int DIV_W = 15,
  parameter int NREG  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_32k,
  input  logic                    bus_start,
  input  logic [$clog2(NREG)-1:0] bus_addr,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_wdata,
  input  logic                    bus_rd,
  input  logic                    bus_stop,
  output logic [7:0]              rdata,
  output logic                    rdata_vld,
  output logic                    sqw_out
);
  tbank_t             tm;
  logic               ld_en, halt, sq_en, sec_stb;
  logic [TIX_W-1:0]   ld_idx;
  logic [7:0]         ld_data;
  logic [RATE_W-1:0]  sq_code;

  rtc_regport #(.NREG(NREG)) u_port (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_stop(bus_stop), .tm(tm), .rdata(rdata), .rdata_vld(rdata_vld),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .halt(halt),
    .sq_en(sq_en), .sq_code(sq_code)
  );

  rtc_prescale #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .tick(tick_32k), .run(~tm[SEC_O][7]),
    .clr(ld_en), .sq_en(sq_en), .sq_code(sq_code),
    .sec_stb(sec_stb), .sq_out(sqw_out)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .sec_stb(sec_stb), .ld_en(ld_en),
    .ld_idx(ld_idx), .ld_data(ld_data), .tm(tm)
  );

  initial begin
    if (NREG <= RATE_O) $error("NREG too small for control bytes");
  end
endmodule

// File: tb/sim_rtc_bcd_core.sv
`timescale 1ns/1ps
module sim_rtc_bcd_core;
  localparam int NREG = 32;
  localparam int AW   = $clog2(NREG);
  localparam int SEC  = 32768;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic bus_start = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_stop = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, rdata;
  logic rdata_vld, sqw_out;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_bcd_core #(.DIV_W(15), .NREG(NREG)) u0 (
    .clk(clk), .rst(rst), .tick_32k(tick), .bus_start(bus_start),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_stop(bus_stop), .rdata(rdata),
    .rdata_vld(rdata_vld), .sqw_out(sqw_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops an expected byte for every read result
  always @(negedge clk) begin
    if (!rst && rdata_vld) begin
      if (exp_q.size() == 0) chk(1'b0, "R12 unexpected read result", rdata, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata == e, t, rdata, e);
      end
    end
  end

  task automatic bstart(input int a);
    bus_start = 1'b1; bus_addr = AW'(a); @(negedge clk); bus_start = 1'b0;
  endtask
  task automatic bstop();
    bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
  endtask
  task automatic bwr(input logic [7:0] d);
    bus_wr = 1'b1; bus_wdata = d; @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic brd(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1'b1; @(negedge clk); bus_rd = 1'b0;
  endtask
  task automatic rdseq(input int a, input int n, input logic [63:0] e, input string tag);
    bstart(a);
    for (int i = 0; i < n; i++) brd(e[8*(n-1-i) +: 8], tag);
    bstop();
  endtask
  task automatic wrseq(input int a, input int n, input logic [63:0] d);
    bstart(a);
    for (int i = 0; i < n; i++) bwr(d[8*(n-1-i) +: 8]);
    bstop();
  endtask
  task automatic ticks(input int n);
    tick = 1'b1; repeat (n) @(negedge clk); tick = 1'b0;
  endtask
  task automatic period(output int p);
    int t0; logic prev;
    t0 = -1; p = -1; prev = sqw_out;
    for (int k = 0; k < 200 && p < 0; k++) begin
      @(negedge clk);
      if (sqw_out && !prev) begin
        if (t0 < 0) t0 = cyc; else p = cyc - t0;
      end
      prev = sqw_out;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int p, highs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rdata == 8'h00, "R1 rdata after reset", rdata, 0);
    chk(!rdata_vld, "R1 rdata_vld after reset", rdata_vld, 0);
    chk(!sqw_out, "R1 sqw_out after reset", sqw_out, 0);
    rdseq(0, 8, 64'h0, "R1 R10 time bytes after reset");
    rdseq(8'h0A, 3, 64'h0, "R1 control bytes after reset");

    // R12 read latency at the ports
    bstart(8'h13);
    exp_q.push_back(8'h00); tag_q.push_back("R12 read data");
    bus_rd = 1'b1; @(negedge clk); bus_rd = 1'b0;
    chk(rdata_vld, "R12 valid one edge after read", rdata_vld, 1);
    @(negedge clk);
    chk(!rdata_vld, "R12 valid lasts one cycle", rdata_vld, 0);
    bstop();

    // R2 R3 R4 R7 R8: full rollover, divider restart, freeze/release
    wrseq(1, 7, 64'h0059_5923_0031_1299);
    ticks(SEC - 1);
    bstart(1);
    brd(8'h59, "R7 no step before 2^DIV_W enables");
    ticks(1);
    brd(8'h59, "R8 minutes frozen during access");
    bstart(8'h0A);
    brd(8'h00, "R8 control access");
    rdseq(0, 8, 64'h0000_0000_0001_0100, "R2 R3 R4 rollover after release");

    // R4 30-day month, R8 release by stop
    wrseq(1, 7, 64'h0059_5923_0030_0424);
    bstart(1);
    brd(8'h59, "R8 seconds at freeze");
    ticks(SEC);
    brd(8'h59, "R8 minutes frozen across a step");
    bstop();
    rdseq(1, 7, 64'h0000_0000_0001_0524, "R4 30-day wrap after stop");

    // R9 halt-update with February
    wrseq(8'h0C, 1, 64'h40);
    wrseq(1, 7, 64'h0059_5923_0028_0225);
    ticks(SEC);
    rdseq(1, 7, 64'h0059_5923_0028_0225, "R9 view held while halted");
    wrseq(8'h0C, 1, 64'h00);
    rdseq(1, 7, 64'h0000_0000_0001_0325, "R9 R4 February wrap after halt clear");

    // R5 stop bit, R6 flags, R4 31-day month not wrapping at 30
    wrseq(1, 7, 64'h00D9_D9E3_0030_0107);
    ticks(SEC);
    rdseq(1, 3, 64'hD9D9E3, "R5 no advance while stopped");
    wrseq(1, 1, 64'h59);
    ticks(SEC);
    rdseq(1, 7, 64'h0000_80C0_0031_0107, "R5 R6 R4 restart keeps flags");

    // R11 square wave
    wrseq(8'h13, 1, 64'h30);
    wrseq(8'h0A, 1, 64'h40);
    tick = 1'b1;
    period(p);
    chk(p == 8, "R11 code 3 period", p, 8);
    wrseq(8'h13, 1, 64'h20);
    period(p);
    chk(p == 4, "R11 code 2 period", p, 4);
    wrseq(8'h13, 1, 64'h00);
    highs = 0;
    repeat (20) begin @(negedge clk); if (sqw_out) highs++; end
    chk(highs == 0, "R11 code 0 holds low", highs, 0);
    wrseq(8'h13, 1, 64'h30);
    wrseq(8'h0A, 1, 64'h00);
    highs = 0;
    repeat (20) begin @(negedge clk); if (sqw_out) highs++; end
    chk(highs == 0, "R11 disabled output low", highs, 0);
    wrseq(8'h13, 1, 64'h10);
    wrseq(8'h0A, 1, 64'h40);
    @(negedge clk);
    chk(sqw_out, "R11 code 1 follows enable high", sqw_out, 1);
    tick = 1'b0;
    @(negedge clk);
    chk(!sqw_out, "R11 code 1 follows enable low", sqw_out, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all reads answered", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule